// File: doc/BRIEF.md
# Periodic Battery Test Sequencer

This block decides when a backup battery gets a health check and keeps the result. Once the supply is in tolerance it waits out a recovery delay and then runs a first test. After that it runs a new test at the end of every long interval. During a test it drives a load-enable signal for a fixed window. While that window is open it samples a comparator flag that goes high when the loaded battery sits below its trip voltage. A single low sample in the window marks the test as failed, and the result takes effect only when the window closes.

A failed test pulls the active-low warning output low. That output is meant to drive an open-drain pad. The warning is sticky: a later periodic test that passes does not release it. The only thing that can release it is a passing test run straight after a power-up, and such a test always runs, even when the warning is already active.

Losing the supply stops all activity. Any test in progress is dropped without a verdict, the load is released, and the warning keeps its value. All time constants are counts of clock ticks, so a system build can scale them to real time with a slow tick enable, and a simulation can keep them short.

Top module: `batt_test_seq`

## Requirements
- R1: During and immediately after synchronous reset, warn_n is 1 (no warning) and load_en is 0.
- R2: A rising clock edge that samples pwr_good high while the block is unpowered starts recovery. load_en then rises on the (REC_TICKS+1)-th rising edge, counting that first edge as edge 1.
- R3: While powered, each test holds load_en high for exactly WIN_TICKS consecutive cycles.
- R4: While powered, load_en stays low for exactly PERIOD_TICKS cycles between the end of one test and the start of the next.
- R5: If batt_low is 1 on any cycle in which load_en is 1, warn_n is 0 (warning) from the edge that ends that window onward.
- R6: warn_n changes only on the edge that ends a test window. It never changes while load_en is high or while no test is running.
- R7: A periodic test that passes leaves an active warning (warn_n = 0) unchanged.
- R8: A passing test that is the first test after power-up sets warn_n to 1, and periodic tests resume on the normal schedule.
- R9: A rising edge that samples pwr_good low forces load_en to 0 and aborts any test in progress. warn_n keeps its value whatever batt_low was during the aborted window.
- R10: While pwr_good is low no test runs and batt_low has no effect on either output.
- R11: A power-up test that fails leaves an active warning in place (warn_n stays 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | High while the supply is in tolerance |
| batt_low | input | 1 | Comparator flag: battery below trip voltage while loaded |
| load_en | output | 1 | Registered; high while the test load must be connected |
| warn_n | output | 1 | Registered active-low battery warning for an open-drain pad |

## Verification
The assertions check on every cycle that the load is released one edge after the supply drops. They also check that the warning moves only on the edge that closes a window, that a test always starts from the end of a recovery or interval count, and that the warning is released only at the end of a power-up test. Other properties need a whole scenario to show. These include the exact recovery, window and interval lengths, stickiness across passing periodic tests, clearing by a power-up retest, and an abort that leaves the verdict untouched. The bench shows them with directed sequences and with long random runs of supply loss and comparator noise, compared cycle by cycle against a reference model.

// File: rtl/btseq_pkg.sv
package btseq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_REC  = 2'd1,
    ST_WAIT = 2'd2,
    ST_TEST = 2'd3
  } btseq_state_e;
endpackage

// File: rtl/btseq_timer.sv
module btseq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/btseq_ctrl.sv
module btseq_ctrl
  import btseq_pkg::*;
#(
  parameter int unsigned REC_TICKS    = 1000,
  parameter int unsigned PERIOD_TICKS = 50000,
  parameter int unsigned WIN_TICKS    = 100,
  parameter int unsigned CW           = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_good,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          load_en,
  output logic          in_test,
  output logic          win_end,
  output logic          pu_test
);
  localparam logic [CW-1:0] REC_LD  = CW'(REC_TICKS - 1);
  localparam logic [CW-1:0] PER_LD  = CW'(PERIOD_TICKS - 1);
  localparam logic [CW-1:0] WIN_LD  = CW'(WIN_TICKS - 1);

  btseq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:  st_d = ST_REC;
      ST_REC:  if (tmr_zero) st_d = ST_TEST;
      ST_TEST: if (tmr_zero) st_d = ST_WAIT;
      ST_WAIT: if (tmr_zero) st_d = ST_TEST;
      default: st_d = ST_OFF;
    endcase
    if (!pwr_good) st_d = ST_OFF;
  end

  always_comb begin
    tmr_load = (st_d != st_q) && (st_d != ST_OFF);
    unique case (st_d)
      ST_REC:  tmr_val = REC_LD;
      ST_WAIT: tmr_val = PER_LD;
      ST_TEST: tmr_val = WIN_LD;
      default: tmr_val = '0;
    endcase
  end

  assign in_test = (st_q == ST_TEST);
  assign win_end = in_test && tmr_zero && pwr_good;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OFF;
      load_en <= 1'b0;
      pu_test <= 1'b1;
    end else begin
      st_q    <= st_d;
      load_en <= (st_d == ST_TEST);
      if (st_q == ST_OFF && pwr_good) pu_test <= 1'b1;
      else if (win_end)               pu_test <= 1'b0;
    end
  end

  // R2: a test only begins when a recovery or interval count runs out
  p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(load_en) |-> ($past(tmr_zero) &&
      ($past(st_q) == ST_REC || $past(st_q) == ST_WAIT)));
endmodule

// File: rtl/btseq_verdict.sv
module btseq_verdict (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic in_test,
  input  logic win_end,
  input  logic pu_test,
  input  logic batt_low,
  output logic warn_n
);
  logic acc_q;
  logic fail_now;

  assign fail_now = acc_q | batt_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= 1'b0;
      warn_n <= 1'b1;
    end else begin
      if (in_test && pwr_good && !win_end) acc_q <= fail_now;
      else                                 acc_q <= 1'b0;
      if (win_end) begin
        if (fail_now)     warn_n <= 1'b0;
        else if (pu_test) warn_n <= 1'b1;
      end
    end
  end

  // R8: the warning is released only at the close of a power-up test
  p_warn_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_n) |-> ($past(pu_test) && $past(in_test)));
endmodule

// File: rtl/batt_test_seq.sv
module batt_test_seq #(
  parameter int unsigned REC_TICKS    = 1000,
  parameter int unsigned PERIOD_TICKS = 50000,
  parameter int unsigned WIN_TICKS    = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic batt_low,
  output logic load_en,
  output logic warn_n
);
  localparam int unsigned MAX_RW = (REC_TICKS > WIN_TICKS) ? REC_TICKS : WIN_TICKS;
  localparam int unsigned MAX_T  = (MAX_RW > PERIOD_TICKS) ? MAX_RW : PERIOD_TICKS;
  localparam int unsigned CW     = $clog2(MAX_T + 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          in_test;
  logic          win_end;
  logic          pu_test;

  btseq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  btseq_ctrl #(
    .REC_TICKS    (REC_TICKS),
    .PERIOD_TICKS (PERIOD_TICKS),
    .WIN_TICKS    (WIN_TICKS),
    .CW           (CW)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (pwr_good),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .load_en  (load_en),
    .in_test  (in_test),
    .win_end  (win_end),
    .pu_test  (pu_test)
  );

  btseq_verdict u_verdict (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (pwr_good),
    .in_test  (in_test),
    .win_end  (win_end),
    .pu_test  (pu_test),
    .batt_low (batt_low),
    .warn_n   (warn_n)
  );

  // R9: supply loss releases the load on the next edge
  p_unpowered_noload_r9: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> !load_en);

  // R6: no verdict change unless a window was open on the previous cycle
  p_warn_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(load_en) |-> $stable(warn_n));

  // R5: a warning only appears as a window closes
  p_warn_set_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(warn_n) |-> ($past(load_en) && !load_en));
endmodule

// File: tb/batt_test_seq_bench.sv
module batt_test_seq_bench;
  localparam int unsigned REC = 8;
  localparam int unsigned PER = 40;
  localparam int unsigned WIN = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b0;
  logic batt_low = 1'b0;
  logic load_en;
  logic warn_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  batt_test_seq #(.REC_TICKS(REC), .PERIOD_TICKS(PER), .WIN_TICKS(WIN)) u_batt_test_seq (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .batt_low(batt_low),
    .load_en(load_en), .warn_n(warn_n)
  );

  // reference model built from the requirements
  int  m_ph = 0;   // 0 unpowered, 1 recovery, 2 interval, 3 window
  int  m_cnt = 0;
  bit  m_acc = 0, m_pu = 1, m_warn = 0, m_load = 0;

  function automatic bit next_is_window(int ph, int cnt, bit pg);
    if (!pg) return 0;
    if (ph == 1 || ph == 2) return (cnt == 0);
    if (ph == 3) return (cnt != 0);
    return 0;
  endfunction

  always @(posedge clk) begin
    m_load <= next_is_window(m_ph, m_cnt, pwr_good);
    if (rst) begin
      m_ph <= 0; m_warn <= 0; m_acc <= 0; m_pu <= 1; m_load <= 0;
    end else if (!pwr_good) begin
      m_ph <= 0; m_acc <= 0;
    end else begin
      case (m_ph)
        0: begin m_ph <= 1; m_cnt <= REC - 1; m_pu <= 1; end
        1, 2: if (m_cnt == 0) begin m_ph <= 3; m_cnt <= WIN - 1; m_acc <= 0; end
              else m_cnt <= m_cnt - 1;
        default: if (m_cnt == 0) begin
          if (m_acc | batt_low) m_warn <= 1;
          else if (m_pu)        m_warn <= 0;
          m_pu <= 0; m_ph <= 2; m_cnt <= PER - 1; m_acc <= 0;
        end else begin
          m_acc <= m_acc | batt_low; m_cnt <= m_cnt - 1;
        end
      endcase
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_load(int lim);
    for (int i = 0; i < lim && !load_en; i++) @(negedge clk);
  endtask

  task automatic wait_unload(int lim);
    for (int i = 0; i < lim && load_en; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_b1a7));
    cyc(3);
    chk("R1", "warn_n in reset", warn_n, 1);
    chk("R1", "load_en in reset", load_en, 0);
    rst = 1'b0;
    cyc(1);
    chk("R1", "warn_n after reset", warn_n, 1);
    batt_low = 1'b1;
    cyc(4);
    chk("R10", "load_en unpowered", load_en, 0);
    chk("R10", "warn_n unpowered with batt_low", warn_n, 1);
    batt_low = 1'b0;

    // R2 recovery length
    pwr_good = 1'b1;
    n = 0;
    do begin cyc(1); n++; end while (!load_en && n < 200);
    chk("R2", "edges until first load", n, REC + 1);
    // R3 window length, passing power-up test
    n = 0;
    while (load_en && n < 200) begin cyc(1); n++; end
    chk("R3", "window length", n, WIN);
    chk("R8", "warn_n after passing power-up test", warn_n, 1);
    // R4 interval
    n = 0;
    while (!load_en && n < 500) begin cyc(1); n++; end
    chk("R4", "interval length", n, PER);

    // R5/R6: one low sample mid-window
    cyc(2);
    batt_low = 1'b1;
    cyc(1);
    batt_low = 1'b0;
    chk("R6", "warn_n while window open", warn_n, 1);
    wait_unload(50);
    chk("R5", "warn_n after failing window", warn_n, 0);
    chk("R6", "load_en closed", load_en, 0);

    // R7: passing periodic test keeps warning
    wait_load(200);
    wait_unload(50);
    chk("R7", "warn_n after passing periodic test", warn_n, 0);

    // R9: abort mid-test with warning active
    wait_load(200);
    cyc(2);
    pwr_good = 1'b0;
    cyc(1);
    chk("R9", "load_en after supply loss", load_en, 0);
    chk("R9", "warn_n after abort", warn_n, 0);
    batt_low = 1'b1;
    cyc(6);
    chk("R10", "load_en while unpowered", load_en, 0);

    // R11: failing power-up retest keeps warning
    pwr_good = 1'b1;
    wait_load(200);
    wait_unload(50);
    chk("R11", "warn_n after failing power-up test", warn_n, 0);

    // R8: passing power-up retest clears warning
    pwr_good = 1'b0;
    batt_low = 1'b0;
    cyc(3);
    pwr_good = 1'b1;
    wait_load(200);
    wait_unload(50);
    chk("R8", "warn_n after passing power-up retest", warn_n, 1);
    n = 0;
    while (!load_en && n < 500) begin cyc(1); n++; end
    chk("R8", "schedule resumes after retest", n, PER);

    // R9: abort with low samples and no warning: verdict untouched
    batt_low = 1'b1;
    cyc(2);
    pwr_good = 1'b0;
    cyc(1);
    chk("R9", "warn_n after aborted failing window", warn_n, 1);
    chk("R9", "load_en after abort", load_en, 0);
    batt_low = 1'b0;
    cyc(2);
    pwr_good = 1'b1;
    cyc(1);
    chk("R2", "model agrees load_en", load_en, m_load);

    // random mix against the reference model
    for (int k = 0; k < 6000; k++) begin
      int r = $urandom_range(0, 999);
      if (pwr_good && r < 4) pwr_good = 1'b0;
      else if (!pwr_good && r < 80) pwr_good = 1'b1;
      batt_low = ($urandom_range(0, 99) < ((k / 1000) % 2 ? 3 : 40));
      cyc(1);
      chk("R3", "load_en vs model", load_en, m_load);
      chk("R5", "warn_n vs model", warn_n, !m_warn);
    end
    finish_run();
  end
endmodule